// File: doc/BRIEF.md
# Word-Addressed Memory Port Controller

This block sits between a microcoded datapath and main memory. It holds three registers: a word address register, a 32-bit data register and an 8-bit byte buffer. Each cycle the current microinstruction supplies three memory control bits: read, write and fetch.

A read or a write works on a whole word. The word address is turned into a byte address by scaling it by four. The access starts in the same cycle that the control bit is asserted. Any register load from the C bus in that cycle is already visible to the memory. Read data reaches the data register one cycle after the memory samples it, so a read issued in cycle k can be used in cycle k+2. Reads can be issued back to back, one per cycle.

A fetch uses the program counter directly as a byte address. The fetched byte lands in the byte buffer on the same two-cycle schedule. The datapath can read the byte buffer in two forms: sign-extended or zero-extended. A read and a fetch may be issued together. A read and a write issued together are illegal: the block flags them and suppresses both strobes.

Top module: `mem_port_ctrl`

## Requirements
- R1: During a legal read or write, the memory byte address equals the word address that the address register holds after this cycle's load (the C bus value when loaded, else its current value), shifted left by two places with the low two bits zero.
- R2: Data returned by memory for a read issued in cycle k is visible on the data register output in cycle k+2.
- R3: Reads issued in consecutive cycles each complete. The Nth of N back-to-back reads is visible at the start of cycle N+2.
- R4: A legal write drives the write strobe in its issue cycle. The write data is the value the data register holds after this cycle's load, and the memory word at the scaled address takes that value.
- R5: When read and write are both asserted, the conflict output is 1 in that cycle and neither memory strobe is driven. Memory is left unchanged, and the data register only takes a C bus load. In every other cycle the conflict output is 0.
- R6: A fetch drives the fetch strobe with the program counter as an unshifted byte address. The addressed byte is visible in the byte buffer in cycle k+2. Byte lane n of a word holds bits 8n+7 down to 8n (little-endian).
- R7: A read and a fetch issued in the same cycle both complete on their own schedules and do not disturb each other.
- R8: The byte buffer is presented both sign-extended (upper bits copy bit 7) and zero-extended to 32 bits.
- R9: The byte buffer keeps its value in every cycle in which no fetch result is arriving.
- R10: While reset is low, the address register, data register and byte buffer are all zero.
- R11: Address and data register loads from the C bus take effect at the next clock edge. When read data arrives in the same cycle as a data register load, the read data wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c_bus_i | input | 32 | Result bus from the ALU and shifter |
| mar_ld_i | input | 1 | Load the word address register from the C bus |
| mdr_ld_i | input | 1 | Load the data register from the C bus |
| pc_i | input | 32 | Program counter (byte address for fetches) |
| rd_i | input | 1 | Microinstruction read bit |
| wr_i | input | 1 | Microinstruction write bit |
| fetch_i | input | 1 | Microinstruction fetch bit |
| mar_o | output | 32 | Word address register |
| mdr_o | output | 32 | Data register |
| mbr_u_o | output | 32 | Byte buffer, zero-extended |
| mbr_s_o | output | 32 | Byte buffer, sign-extended |
| conflict_o | output | 1 | Read and write requested together |
| mem_addr_o | output | 32 | Word port byte address |
| mem_wdata_o | output | 32 | Word port write data |
| mem_rd_o | output | 1 | Word port read strobe |
| mem_we_o | output | 1 | Word port write strobe |
| mem_rdata_i | input | 32 | Word port read data, one cycle after the strobe |
| fetch_addr_o | output | 32 | Byte port address |
| fetch_rd_o | output | 1 | Byte port read strobe |
| fetch_data_i | input | 8 | Byte port read data, one cycle after the strobe |

## Verification
The capture assertions rely on one assumption about the memory: the word and byte ports return their data in the cycle that follows the strobe. They compare the registers with whatever the ports showed in that cycle, so they make no assumption about the memory contents. The bench memory is a synchronous model that reads before it writes at the same edge, which matches that assumption. Random stimulus keeps word addresses below 256 and program counters below 1024 so every access lands in that model. It issues read and write together only rarely, so that the conflict path is exercised without starving ordinary traffic.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

   // microinstruction memory control bits
   typedef struct packed {
      logic rd;
      logic wr;
      logic fetch;
   } mem_cmd_t;

   // number of address bits that select a byte inside a word
   function automatic int lane_bits(input int word_w, input int byte_w);
      int n;
      n = 0;
      while ((byte_w << n) < word_w) n++;
      return n;
   endfunction

endpackage

// File: rtl/mpc_data_port.sv
module mpc_data_port #(
   parameter int WORD_W    = 32,
   parameter int ADDR_W    = 32,
   parameter int LANE_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] c_bus_i,
   input  logic              mar_ld_i,
   input  logic              mdr_ld_i,
   input  logic              rd_i,
   input  logic              wr_i,
   output logic [WORD_W-1:0] mar_o,
   output logic [WORD_W-1:0] mdr_o,
   output logic              conflict_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [WORD_W-1:0] mem_wdata_o,
   output logic              mem_rd_o,
   output logic              mem_we_o,
   input  logic [WORD_W-1:0] mem_rdata_i
);

   logic [WORD_W-1:0] mar_q, mdr_q, mar_nxt, mdr_nxt;
   logic              rd_pend_q;

   assign mar_nxt     = mar_ld_i ? c_bus_i : mar_q;
   assign mdr_nxt     = mdr_ld_i ? c_bus_i : mdr_q;
   assign conflict_o  = rd_i & wr_i;
   assign mem_rd_o    = rd_i & ~wr_i;
   assign mem_we_o    = wr_i & ~rd_i;
   assign mem_wdata_o = mdr_nxt;
   assign mem_addr_o  = {mar_nxt[ADDR_W-LANE_BITS-1:0], {LANE_BITS{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mar_q     <= '0;
         mdr_q     <= '0;
         rd_pend_q <= 1'b0;
      end else begin
         mar_q     <= mar_nxt;
         rd_pend_q <= mem_rd_o;
         mdr_q     <= rd_pend_q ? mem_rdata_i : mdr_nxt;
      end
   end

   assign mar_o = mar_q;
   assign mdr_o = mdr_q;

   // returned word is in the data register two cycles after issue
   assert_mdr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> ##2 (mdr_q == $past(mem_rdata_i)));

   // word port addresses are always word aligned
   assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o || mem_we_o) |-> (mem_addr_o[LANE_BITS-1:0] == '0));

   // an illegal pair drives no strobe
   assert_conflict_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && wr_i) |-> (!mem_rd_o && !mem_we_o && conflict_o));

endmodule

// File: rtl/mpc_fetch_port.sv
module mpc_fetch_port #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_i,
   input  logic [WORD_W-1:0] pc_i,
   output logic [ADDR_W-1:0] fetch_addr_o,
   output logic              fetch_rd_o,
   input  logic [BYTE_W-1:0] fetch_data_i,
   output logic [WORD_W-1:0] mbr_u_o,
   output logic [WORD_W-1:0] mbr_s_o
);

   logic [BYTE_W-1:0] mbr_q;
   logic              fetch_pend_q;

   assign fetch_rd_o   = fetch_i;
   assign fetch_addr_o = pc_i[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mbr_q        <= '0;
         fetch_pend_q <= 1'b0;
      end else begin
         fetch_pend_q <= fetch_i;
         if (fetch_pend_q) mbr_q <= fetch_data_i;
      end
   end

   generate
      if (WORD_W > BYTE_W) begin : g_extend
         assign mbr_u_o = {{(WORD_W-BYTE_W){1'b0}}, mbr_q};
         assign mbr_s_o = {{(WORD_W-BYTE_W){mbr_q[BYTE_W-1]}}, mbr_q};
      end else begin : g_same
         assign mbr_u_o = mbr_q;
         assign mbr_s_o = mbr_q;
      end
   endgenerate

   // fetched byte reaches the buffer two cycles after issue
   assert_mbr_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_rd_o |-> ##2 (mbr_q == $past(fetch_data_i)));

   // no arriving byte, no change
   assert_mbr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_pend_q |=> $stable(mbr_q));

endmodule

// File: rtl/mem_port_ctrl.sv
module mem_port_ctrl #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] c_bus_i,
   input  logic              mar_ld_i,
   input  logic              mdr_ld_i,
   input  logic [WORD_W-1:0] pc_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic              fetch_i,
   output logic [WORD_W-1:0] mar_o,
   output logic [WORD_W-1:0] mdr_o,
   output logic [WORD_W-1:0] mbr_u_o,
   output logic [WORD_W-1:0] mbr_s_o,
   output logic              conflict_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [WORD_W-1:0] mem_wdata_o,
   output logic              mem_rd_o,
   output logic              mem_we_o,
   input  logic [WORD_W-1:0] mem_rdata_i,
   output logic [ADDR_W-1:0] fetch_addr_o,
   output logic              fetch_rd_o,
   input  logic [BYTE_W-1:0] fetch_data_i
);
   import mpc_pkg::*;

   localparam int LANE_BITS = lane_bits(WORD_W, BYTE_W);

   generate
      if (WORD_W % BYTE_W != 0 || (BYTE_W << LANE_BITS) != WORD_W) begin : g_bad_word
         $error("WORD_W must be a power-of-two multiple of BYTE_W");
      end
      if (ADDR_W > WORD_W || ADDR_W <= LANE_BITS) begin : g_bad_addr
         $error("ADDR_W must lie in (LANE_BITS, WORD_W]");
      end
   endgenerate

   mem_cmd_t cmd;
   assign cmd = '{rd: rd_i, wr: wr_i, fetch: fetch_i};

   mpc_data_port #(
      .WORD_W(WORD_W), .ADDR_W(ADDR_W), .LANE_BITS(LANE_BITS)
   ) i_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .c_bus_i    (c_bus_i),
      .mar_ld_i   (mar_ld_i),
      .mdr_ld_i   (mdr_ld_i),
      .rd_i       (cmd.rd),
      .wr_i       (cmd.wr),
      .mar_o      (mar_o),
      .mdr_o      (mdr_o),
      .conflict_o (conflict_o),
      .mem_addr_o (mem_addr_o),
      .mem_wdata_o(mem_wdata_o),
      .mem_rd_o   (mem_rd_o),
      .mem_we_o   (mem_we_o),
      .mem_rdata_i(mem_rdata_i)
   );

   mpc_fetch_port #(
      .WORD_W(WORD_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
   ) i_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_i     (cmd.fetch),
      .pc_i        (pc_i),
      .fetch_addr_o(fetch_addr_o),
      .fetch_rd_o  (fetch_rd_o),
      .fetch_data_i(fetch_data_i),
      .mbr_u_o     (mbr_u_o),
      .mbr_s_o     (mbr_s_o)
   );

   // fetch and read strobes follow their own control bits only
   assert_fetch_independent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && fetch_i && !wr_i) |-> (mem_rd_o && fetch_rd_o));

endmodule

// File: tb/test_mem_port_ctrl.sv
module test_mem_port_ctrl;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] c_bus_i = '0, pc_i = '0;
   logic        mar_ld_i = 0, mdr_ld_i = 0, rd_i = 0, wr_i = 0, fetch_i = 0;
   logic [31:0] mar_o, mdr_o, mbr_u_o, mbr_s_o, mem_addr_o, mem_wdata_o, fetch_addr_o;
   logic        conflict_o, mem_rd_o, mem_we_o, fetch_rd_o;
   logic [31:0] mem_rdata_i = '0;
   logic [7:0]  fetch_data_i = '0;

   int vectors = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_port_ctrl i_mem_port_ctrl (.*);

   // ---------------- memory model (environment) ----------------
   logic [31:0] ram [256];
   logic [31:0] ref_mem [256];

   function automatic logic [31:0] init_word(input int i);
      return (i * 32'h9E37_79B1) ^ 32'h80C0_A050;
   endfunction

   function automatic logic [7:0] lane_of(input logic [31:0] w, input logic [1:0] l);
      return w[8*l +: 8];
   endfunction

   always_ff @(posedge clk) begin
      if (mem_rd_o) mem_rdata_i <= ram[mem_addr_o[9:2]];
      if (fetch_rd_o) fetch_data_i <= lane_of(ram[fetch_addr_o[9:2]], fetch_addr_o[1:0]);
      if (mem_we_o) ram[mem_addr_o[9:2]] <= mem_wdata_o;
   end

   // ---------------- reference state ----------------
   logic [31:0] m_mar = 0, m_mdr = 0, m_rdval = 0;
   logic [7:0]  m_mbr = 0, m_fval = 0;
   logic        m_rdpend = 0, m_fpend = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one microinstruction cycle; called at a negative edge
   task automatic step(input string tag, input logic rd, input logic wr, input logic fe,
                       input logic ml, input logic dl, input logic [31:0] c,
                       input logic [31:0] pc);
      logic [31:0] nm, nd, new_mdr, n_rdval;
      logic [7:0]  new_mbr, n_fval;
      rd_i = rd; wr_i = wr; fetch_i = fe; mar_ld_i = ml; mdr_ld_i = dl;
      c_bus_i = c; pc_i = pc;
      #1;
      nm = ml ? c : m_mar;
      nd = dl ? c : m_mdr;
      check("R5 conflict", {31'b0, conflict_o}, {31'b0, rd & wr});
      if (rd && !wr) begin
         check("R1 read addr", mem_addr_o, nm << 2);
         check("R7 read strobe", {31'b0, mem_rd_o}, 32'd1);
      end
      if (wr && !rd) begin
         check("R1 write addr", mem_addr_o, nm << 2);
         check("R4 write data", mem_wdata_o, nd);
         check("R4 write strobe", {31'b0, mem_we_o}, 32'd1);
      end
      if (rd && wr) check("R5 strobes", {30'b0, mem_rd_o, mem_we_o}, 32'd0);
      if (fe) begin
         check("R6 fetch addr", fetch_addr_o, pc);
         check("R7 fetch strobe", {31'b0, fetch_rd_o}, 32'd1);
      end
      n_rdval = ref_mem[nm[7:0]];
      n_fval  = lane_of(ref_mem[pc[9:2]], pc[1:0]);
      new_mdr = m_rdpend ? m_rdval : nd;
      new_mbr = m_fpend ? m_fval : m_mbr;
      if (wr && !rd) ref_mem[nm[7:0]] = nd;
      m_rdpend = rd & ~wr; m_fpend = fe;
      m_rdval = n_rdval; m_fval = n_fval;
      m_mar = nm; m_mdr = new_mdr; m_mbr = new_mbr;
      @(posedge clk);
      @(negedge clk);
      check({tag, " R11 mar"}, mar_o, m_mar);
      check({tag, " R2 mdr"}, mdr_o, m_mdr);
      check({tag, " R6 mbr"}, mbr_u_o, {24'b0, m_mbr});
      check({tag, " R8 mbr signed"}, mbr_s_o, {{24{m_mbr[7]}}, m_mbr});
   endtask

   task automatic idle(input string tag);
      step(tag, 0, 0, 0, 0, 0, 32'h0, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int seed;
      for (int i = 0; i < 256; i++) begin
         ram[i] = init_word(i);
         ref_mem[i] = init_word(i);
      end
      seed = 32'h5EED_1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 mar", mar_o, 0);
      check("R10 mdr", mdr_o, 0);
      check("R10 mbr", mbr_u_o, 0);
      rst_n = 1'b1;

      // R1 R2: load address and read in one microinstruction
      step("R2", 1, 0, 0, 1, 0, 32'd5, 0);
      idle("R2");
      idle("R2");
      // R3: four back-to-back pipelined reads
      for (int k = 0; k < 4; k++) step("R3", 1, 0, 0, 1, 0, 32'd20 + k, 0);
      idle("R3"); idle("R3");
      // R4: write, then read it back
      step("R4", 0, 0, 0, 1, 0, 32'd10, 0);
      step("R4", 0, 1, 0, 0, 1, 32'hAABB_CCDD, 0);
      step("R4", 1, 0, 0, 1, 0, 32'd10, 0);
      idle("R4"); idle("R4");
      // R5: illegal pair leaves memory alone, then read to prove it
      step("R5", 1, 1, 0, 1, 1, 32'd33, 0);
      idle("R5");
      step("R5", 1, 0, 0, 0, 0, 0, 0);
      idle("R5"); idle("R5");
      // R6 R8: each byte lane, then R9 hold
      for (int l = 0; l < 4; l++) step("R6", 0, 0, 1, 0, 0, 0, 32'd64 + l);
      idle("R9"); idle("R9"); idle("R9");
      // R7: read and fetch together
      step("R7", 1, 0, 1, 1, 0, 32'd7, 32'd301);
      idle("R7"); idle("R7");
      // R11: data load in the cycle read data arrives
      step("R11", 1, 0, 0, 1, 0, 32'd44, 0);
      step("R11", 0, 0, 0, 0, 1, 32'h1234_5678, 0);
      idle("R11");

      // constrained random traffic
      for (int n = 0; n < 1500; n++) begin
         logic rd, wr, fe;
         rd = ($urandom % 3) == 0;
         wr = ($urandom % 4) == 0;
         if (rd && wr && ($urandom % 8) != 0) wr = 0;
         fe = ($urandom % 2) == 0;
         step("rand", rd, wr, fe, ($urandom % 2) == 0, ($urandom % 2) == 0,
              ($urandom % 256), ($urandom % 1024));
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule